// File: doc/BRIEF.md
# Processor Address Region Router

This block sorts every memory request coming from the processor side by its physical address and names the one place it must go: the downstream system link, PCIe port A, the interrupt-message path, the configuration-space path, DRAM, or an abort. A request is presented for one cycle with its address, direction, write data and a valid flag. The chosen destination comes back as a one-hot vector on the following clock, together with a response strobe.

Two small pieces of firmware-owned state shape the decode. The first is a base register that positions the 256 MiB configuration aperture on any 256 MiB boundary. The second is an enable flag for the fixed interrupt-controller windows. Until firmware sets that flag, those windows are routed subtractively to the system link.

The message-interrupt window is accepted for writes only, and the write data is handed on to the interrupt path. A read of that window is aborted with an error flag and all-ones data. None of these windows ever lands in DRAM.

Top module: `addr_region_router`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one `rsp_valid` pulse one clock later, carrying a one-hot `rsp_target`. The target bits are: bit 0 system link, bit 1 PCIe port A, bit 2 interrupt message, bit 3 configuration, bit 4 DRAM, bit 5 abort. With no request, `rsp_valid`, `rsp_target` and `rsp_error` are zero on the next clock.
- R2: A write to 0xFEE0_0000..0xFEEF_FFFF targets the interrupt-message path (bit 2), and `msi_data` carries that request's write data. Such a write never targets DRAM. On every other response `msi_data` is zero.
- R3: A read of 0xFEE0_0000..0xFEEF_FFFF targets abort (bit 5), with `rsp_error` high and `rsp_rdata` all ones. Every response that is not aborted has `rsp_error` low and `rsp_rdata` zero.
- R4: Addresses 0xFEC0_0000..0xFEC7_FFFF target the system link, whether or not the windows are enabled.
- R5: With the windows enabled, 0xFEC8_0000..0xFEC8_0FFF and 0xFEC8_1000..0xFEC8_1FFF target PCIe port A.
- R6: With the windows disabled, those two windows target the system link.
- R7: The configuration aperture covers the 256 MiB whose address bits [35:28] equal the base register, and it targets configuration (bit 3).
- R8: A cycle with `base_we` high loads only `base_wdata[35:28]` into the base register, and the lower bits are ignored. The aperture moves to the new base from the next request on.
- R9: Decode priority is fixed: the message window first, then the interrupt-controller windows, then the aperture. Every other address, including 0xFEC8_2000 and up and 0xFED0_0000..0xFEDF_FFFF, targets DRAM.
- R10: Reset returns the base register to 0xE000_0000 and disables the interrupt-controller windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 36 | Physical byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data for message forwarding |
| base_we | input | 1 | Load the aperture base register |
| base_wdata | input | 36 | New aperture base; only bits [35:28] are kept |
| win_en_we | input | 1 | Load the window-enable flag |
| win_en_val | input | 1 | 1 enables the interrupt-controller windows |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_target | output | 6 | One-hot destination |
| rsp_error | output | 1 | Aborted access |
| rsp_rdata | output | 32 | All ones on abort, otherwise zero |
| msi_data | output | 32 | Forwarded write data for a message-interrupt write |

## Verification
The assertions assume that the control writes (`base_we`, `win_en_we`) and requests arrive in separate cycles. They also assume that inputs are known whenever `req_valid` is high. The bench meets both assumptions by driving every input on the falling edge and by issuing configuration writes and requests from separate tasks that never overlap. The assertions also treat `req_valid` as a single-cycle, unthrottled stream with no backpressure. The stimulus therefore includes back-to-back requests as well as idle gaps, so that both strobe rules are exercised.

// File: rtl/arr_pkg.sv
package arr_pkg;
  localparam int PA_W   = 36;
  localparam int DATA_W = 32;

  localparam int N_TGT   = 6;
  localparam int T_SYS   = 0;
  localparam int T_PCIE  = 1;
  localparam int T_MSI   = 2;
  localparam int T_CFG   = 3;
  localparam int T_DRAM  = 4;
  localparam int T_ABORT = 5;

  localparam int N_WIN = 4;
  localparam int W_MSI = 0;
  localparam int W_IO0 = 1;
  localparam int W_IO2 = 2;
  localparam int W_IO3 = 3;

  localparam int APER_SHIFT = 28;
  localparam int BASE_W     = PA_W - APER_SHIFT;
  localparam logic [BASE_W-1:0] BASE_RST = 8'h0E;

  typedef logic [PA_W-1:0] paddr_t;
  typedef logic [N_TGT-1:0] tgt_t;

  localparam paddr_t WIN_LO [N_WIN] = '{
    36'h0_FEE0_0000, 36'h0_FEC0_0000, 36'h0_FEC8_0000, 36'h0_FEC8_1000};
  localparam paddr_t WIN_HI [N_WIN] = '{
    36'h0_FEEF_FFFF, 36'h0_FEC7_FFFF, 36'h0_FEC8_0FFF, 36'h0_FEC8_1FFF};
endpackage

// File: rtl/arr_rst_sync.sv
module arr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_ns = out_q;
endmodule

// File: rtl/arr_win_cmp.sv
module arr_win_cmp #(
  parameter int PA_W = arr_pkg::PA_W,
  parameter logic [PA_W-1:0] LO = '0,
  parameter logic [PA_W-1:0] HI = '0
) (
  input  logic [PA_W-1:0] addr,
  output logic            hit
);
  always_comb begin
    hit = (addr >= LO) && (addr <= HI);
  end
endmodule

// File: rtl/arr_ctl_regs.sv
module arr_ctl_regs
  import arr_pkg::*;
#(
  parameter int AW = PA_W,
  parameter int SH = APER_SHIFT,
  localparam int BW = AW - SH
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          win_en_we,
  input  logic          win_en_val,
  output logic [BW-1:0] base,
  output logic          win_on
);
  logic [BW-1:0] base_q, base_d;
  logic          win_q, win_d;

  always_comb begin
    base_d = base_q;
    win_d  = win_q;
    if (base_we)   base_d = base_wdata[AW-1:SH];
    if (win_en_we) win_d  = win_en_val;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      base_q <= BW'(BASE_RST);
      win_q  <= 1'b0;
    end else begin
      if (base_we)   base_q <= base_d;
      if (win_en_we) win_q  <= win_d;
    end
  end

  assign base   = base_q;
  assign win_on = win_q;

  p_base_load_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    base_we |=> base == $past(base_wdata[AW-1:SH]));
  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !base_we |=> $stable(base));
  p_win_hold_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    !win_en_we |=> $stable(win_on));
endmodule

// File: rtl/arr_decode.sv
module arr_decode
  import arr_pkg::*;
#(
  parameter int AW = PA_W,
  parameter int SH = APER_SHIFT,
  parameter int NW = N_WIN,
  localparam int BW = AW - SH
) (
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  logic [BW-1:0] base,
  input  logic          win_on,
  input  logic [NW-1:0] win_hit,
  output tgt_t          tgt
);
  logic io_hi_hit;
  logic aper_hit;

  always_comb begin
    io_hi_hit = win_hit[W_IO2] | win_hit[W_IO3];
    aper_hit  = (addr[AW-1:SH] == base);
    tgt       = '0;
    if (win_hit[W_MSI]) begin
      if (write) tgt[T_MSI]   = 1'b1;
      else       tgt[T_ABORT] = 1'b1;
    end else if (win_hit[W_IO0]) begin
      tgt[T_SYS] = 1'b1;
    end else if (io_hi_hit) begin
      if (win_on) tgt[T_PCIE] = 1'b1;
      else        tgt[T_SYS]  = 1'b1;
    end else if (aper_hit) begin
      tgt[T_CFG] = 1'b1;
    end else begin
      tgt[T_DRAM] = 1'b1;
    end
  end
endmodule

// File: rtl/arr_rsp_reg.sv
module arr_rsp_reg
  import arr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          req_valid,
  input  tgt_t          tgt,
  input  logic [DW-1:0] wdata,
  output logic          rsp_valid,
  output tgt_t          rsp_target,
  output logic          rsp_error,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] msi_data
);
  logic          vld_q, vld_d;
  tgt_t          tgt_q, tgt_d;
  logic          err_q, err_d;
  logic [DW-1:0] rd_q, rd_d;
  logic [DW-1:0] md_q, md_d;
  logic          upd_en;

  always_comb begin
    vld_d = req_valid;
    tgt_d = '0;
    err_d = 1'b0;
    rd_d  = '0;
    md_d  = '0;
    if (req_valid) begin
      tgt_d = tgt;
      err_d = tgt[T_ABORT];
      rd_d  = {DW{tgt[T_ABORT]}};
      md_d  = tgt[T_MSI] ? wdata : '0;
    end
    upd_en = req_valid | vld_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q <= 1'b0;
      tgt_q <= '0;
      err_q <= 1'b0;
      rd_q  <= '0;
      md_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (upd_en) begin
        tgt_q <= tgt_d;
        err_q <= err_d;
        rd_q  <= rd_d;
        md_q  <= md_d;
      end
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_target = tgt_q;
  assign rsp_error  = err_q;
  assign rsp_rdata  = rd_q;
  assign msi_data   = md_q;
endmodule

// File: rtl/addr_region_router.sv
module addr_region_router
  import arr_pkg::*;
#(
  parameter int AW = PA_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          win_en_we,
  input  logic          win_en_val,
  output logic          rsp_valid,
  output logic [N_TGT-1:0] rsp_target,
  output logic          rsp_error,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] msi_data
);
  localparam int BW = AW - APER_SHIFT;

  logic          rst_ns;
  logic [BW-1:0] base;
  logic          win_on;
  logic [N_WIN-1:0] win_hit;
  tgt_t          tgt;

  arr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  arr_ctl_regs #(.AW(AW), .SH(APER_SHIFT)) u_ctl (
    .clk(clk), .rst_ns(rst_ns),
    .base_we(base_we), .base_wdata(base_wdata),
    .win_en_we(win_en_we), .win_en_val(win_en_val),
    .base(base), .win_on(win_on));

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    arr_win_cmp #(.PA_W(AW), .LO(AW'(WIN_LO[w])), .HI(AW'(WIN_HI[w]))) u_cmp (
      .addr(req_addr), .hit(win_hit[w]));
  end

  arr_decode #(.AW(AW), .SH(APER_SHIFT), .NW(N_WIN)) u_dec (
    .addr(req_addr), .write(req_write), .base(base), .win_on(win_on),
    .win_hit(win_hit), .tgt(tgt));

  arr_rsp_reg #(.DW(DW)) u_rsp (
    .clk(clk), .rst_ns(rst_ns), .req_valid(req_valid), .tgt(tgt),
    .wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
    .rsp_error(rsp_error), .rsp_rdata(rsp_rdata), .msi_data(msi_data));

  logic in_msi, in_io0, in_io_hi;
  assign in_msi   = req_addr[AW-1:20] == 16'h0FEE;
  assign in_io0   = req_addr[AW-1:19] == 17'h01FD8;
  assign in_io_hi = req_addr[AW-1:13] == 23'h07F640;

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid |=> rsp_valid);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_valid |=> !rsp_valid && rsp_target == '0 && !rsp_error);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |-> $countones(rsp_target) == 1);
  p_msi_fwd_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid && req_write && in_msi |=>
      rsp_target[T_MSI] && !rsp_target[T_DRAM] && msi_data == $past(req_wdata));
  p_msi_abort_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid && !req_write && in_msi |=>
      rsp_target[T_ABORT] && rsp_error && (&rsp_rdata));
  p_io0_sys_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid && in_io0 |=> rsp_target[T_SYS]);
  p_io_hi_en_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid && in_io_hi && win_on |=> rsp_target[T_PCIE]);
  p_io_hi_dis_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid && in_io_hi && !win_on |=> rsp_target[T_SYS]);
endmodule

// File: tb/addr_region_router_test.sv
module addr_region_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, base_we, win_en_we, win_en_val;
  logic [35:0] req_addr, base_wdata;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_error;
  logic [5:0]  rsp_target;
  logic [31:0] rsp_rdata, msi_data;

  int n_chk = 0;
  int n_bad = 0;

  // target bits: 0 sys, 1 pcie, 2 msi, 3 cfg, 4 dram, 5 abort
  localparam logic [5:0] SYS = 6'h01, PCIE = 6'h02, MSI = 6'h04,
                         CFG = 6'h08, DRAM = 6'h10, ABRT = 6'h20;

  // {address, write, expected target}; windows disabled, base 0xE
  localparam logic [42:0] VEC [NV] = '{
    {36'h0_E000_0000, 1'b0, CFG},   // R7
    {36'h0_EFFF_FFFC, 1'b1, CFG},   // R7
    {36'h0_DFFF_FFFC, 1'b0, DRAM},  // R9
    {36'h0_F000_0000, 1'b0, DRAM},  // R9
    {36'h0_FEC0_0000, 1'b0, SYS},   // R4
    {36'h0_FEC7_FFFC, 1'b1, SYS},   // R4
    {36'h0_FEC8_0000, 1'b0, SYS},   // R6
    {36'h0_FEC8_1FFC, 1'b1, SYS},   // R6
    {36'h0_FEC8_2000, 1'b0, DRAM},  // R9
    {36'h0_FEE0_0000, 1'b1, MSI},   // R2
    {36'h0_FEEF_FFFC, 1'b1, MSI},   // R2
    {36'h0_FEE8_0000, 1'b0, ABRT},  // R3
    {36'h0_FEDF_FFFC, 1'b1, DRAM},  // R9
    {36'h0_FEF0_0000, 1'b1, DRAM},  // R9
    {36'h0_0000_0000, 1'b0, DRAM},  // R9
    {36'hF_E000_0000, 1'b0, DRAM}   // R7 upper bits differ
  };

  addr_region_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .base_we(base_we),
    .base_wdata(base_wdata), .win_en_we(win_en_we), .win_en_val(win_en_val),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata), .msi_data(msi_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_base(logic [35:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic set_win(logic v);
    @(negedge clk); win_en_we = 1'b1; win_en_val = v;
    @(negedge clk); win_en_we = 1'b0;
  endtask

  // issue one request and check the response on the following negedge
  task automatic req_chk(string req, logic [35:0] a, logic w, logic [31:0] d,
                         logic [5:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " strobe"}, 64'(rsp_valid), 64'd1);
    check({req, " target"}, 64'(rsp_target), 64'(exp));
    check({req, " error"}, 64'(rsp_error), 64'(exp[5]));
    check({req, " rdata"}, 64'(rsp_rdata), exp[5] ? 64'hFFFF_FFFF : 64'd0);
    check({req, " msi_data"}, 64'(msi_data), exp[2] ? 64'(d) : 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; base_we = 1'b0; base_wdata = '0;
    win_en_we = 1'b0; win_en_val = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R1 quiet outputs)
    check("R1 reset strobe", 64'(rsp_valid), 64'd0);
    check("R1 reset target", 64'(rsp_target), 64'd0);

    for (int i = 0; i < NV; i++) begin
      req_chk("R1 vector table", VEC[i][42:7], VEC[i][6], 32'hA500_0000 + 32'(i),
              VEC[i][5:0]);
    end

    // R1: idle cycle yields no strobe
    @(negedge clk);
    check("R1 idle strobe", 64'(rsp_valid), 64'd0);
    check("R1 idle target", 64'(rsp_target), 64'd0);

    // R1: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_addr = 36'h0_E000_0040; req_write = 1'b0;
    @(negedge clk);
    check("R1 b2b first", 64'(rsp_target), 64'(CFG));
    req_addr = 36'h0_FEE0_0010; req_write = 1'b1; req_wdata = 32'h1234_5678;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 b2b second", 64'(rsp_target), 64'(MSI));
    check("R2 b2b data", 64'(msi_data), 64'h1234_5678);

    // R5 / R4 with windows enabled
    set_win(1'b1);
    req_chk("R5 win2 lo", 36'h0_FEC8_0000, 1'b0, 32'h0, PCIE);
    req_chk("R5 win3 hi", 36'h0_FEC8_1FFC, 1'b1, 32'h0, PCIE);
    req_chk("R4 win0 enabled", 36'h0_FEC4_0000, 1'b0, 32'h0, SYS);
    req_chk("R9 past win3", 36'h0_FEC8_2000, 1'b0, 32'h0, DRAM);

    // R8: relocate aperture with junk in lower bits
    set_base(36'h0_7ABC_DEF0);
    req_chk("R8 new base lo", 36'h0_7000_0000, 1'b0, 32'h0, CFG);
    req_chk("R8 new base hi", 36'h0_7FFF_FFFC, 1'b1, 32'h0, CFG);
    req_chk("R8 old base", 36'h0_E000_0000, 1'b0, 32'h0, DRAM);
    req_chk("R8 below base", 36'h0_6FFF_FFFC, 1'b0, 32'h0, DRAM);

    // R9: aperture overlapping the fixed windows
    set_base(36'h0_FFFF_FFFF);
    req_chk("R9 cfg over win2", 36'h0_FEC8_0000, 1'b0, 32'h0, PCIE);
    req_chk("R9 cfg over msi wr", 36'h0_FEE0_0000, 1'b1, 32'hCAFE_F00D, MSI);
    req_chk("R9 cfg over msi rd", 36'h0_FEE0_0000, 1'b0, 32'h0, ABRT);
    req_chk("R9 cfg over win0", 36'h0_FEC0_0000, 1'b0, 32'h0, SYS);
    req_chk("R9 cfg elsewhere", 36'h0_F000_0000, 1'b0, 32'h0, CFG);

    // R10: reset restores base and disables windows
    do_reset();
    check("R10 post reset strobe", 64'(rsp_valid), 64'd0);
    req_chk("R10 base restored", 36'h0_E000_0000, 1'b0, 32'h0, CFG);
    req_chk("R10 old base gone", 36'h0_F000_0000, 1'b0, 32'h0, DRAM);
    req_chk("R10 windows off", 36'h0_FEC8_1000, 1'b0, 32'h0, SYS);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule